// File: doc/BRIEF.md
# Field-Masked Program Status Register

This block holds a 32-bit processor status word. The word is divided into four byte fields: control (bits 7:0), extension (bits 15:8), status (bits 23:16) and flags (bits 31:24). Software reads the whole word at once. It writes the word through a 4-bit byte-select mask, and the data comes from either a register operand or an immediate operand. Only the bytes whose mask bit is set change. The control byte carries the processor mode in its low bits, the interrupt-disable bits and an instruction-set state bit. The block drives the interrupt-disable bit and the mode bits out as dedicated outputs.

The current privilege level limits which bytes a write may change. The level is decoded from the mode bits into one of two named states. In `LVL_PRIV`, every mode other than the user code, a write may change any byte. In `LVL_USER`, mode equal to the user code, a write may change only the flags byte. The only transition is `LVL_PRIV -> LVL_USER`, taken when a privileged write loads the user code into the control byte. No write made in `LVL_USER` can leave that state. A user-mode write that selects a privileged byte leaves that byte unchanged and raises a one-cycle ignored-write pulse.

An ALU can also update the four condition flags in the top nibble. When the ALU and a software write both target the flags byte in the same cycle, the software write wins.

Top module: `psr_reg`

## Requirements
- R1: After reset `rd_data` is 0x000000D3: mode bits 4:0 = 10011, interrupt-disable bit 7 = 1, second interrupt-disable bit 6 = 1, all other bits 0. `irq_off` is 1, `mode` is 10011 and `wr_ignored` is 0.
- R2: A write (`wr_en`=1) updates byte i (bits 8i+7:8i) only when `wr_mask[i]` is set. Mask bit 0 selects control (7:0), bit 1 extension (15:8), bit 2 status (23:16) and bit 3 flags (31:24). Unselected bytes keep their value. With `wr_en`=0 the mask has no effect. The new value is visible the cycle after the write edge.
- R3: `wr_src_imm`=1 takes the write data from `wr_imm_data`. `wr_src_imm`=0 takes it from `wr_reg_data`.
- R4: `rd_data` presents the whole register. `irq_off` equals bit 7, so clearing bit 7 drives `irq_off` low. `mode` equals bits 4:0.
- R5: While `mode` equals 10000 (user), a write leaves the control, extension and status bytes unchanged. The flags byte is still written when `wr_mask[3]` is set.
- R6: `alu_flag_we`=1 loads `alu_flags[3:0]` into bits 31:28. Bits 27:0 are left unchanged. This applies in every mode.
- R7: If a write with `wr_mask[3]` set and an ALU update occur in the same cycle, the whole flags byte comes from the write data. If the write does not select the flags byte, both updates take effect.
- R8: A write in user mode with any of `wr_mask[2:0]` set drives `wr_ignored` high for exactly the next cycle. Privileged writes and flags-only user writes leave it low.
- R9: The privilege check uses the mode held before the write. A privileged write that loads 10000 into the control byte takes full effect. After that, no write can leave user mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Move-to-status write strobe |
| wr_mask | input | 4 | Byte-select mask (bit 0 control ... bit 3 flags) |
| wr_src_imm | input | 1 | 1: immediate operand, 0: register operand |
| wr_reg_data | input | 32 | Register operand |
| wr_imm_data | input | 32 | Immediate operand |
| alu_flag_we | input | 1 | ALU condition-flag update strobe |
| alu_flags | input | 4 | New condition flags for bits 31:28 |
| rd_data | output | 32 | Whole register (move-from-status) |
| irq_off | output | 1 | Interrupt-disable bit 7 |
| mode | output | 5 | Processor mode bits 4:0 |
| wr_ignored | output | 1 | One-cycle pulse for a blocked privileged-field write |

## Verification
The bench builds the block with its default parameters: 8-bit fields, a 5-bit mode field, user code 10000 and reset mode 10011. With a privileged reset mode the bench can first exercise every byte lane, both operand sources and the ALU-against-software conflict. It then enters user mode through an ordinary control-byte write. Once in user mode, it covers blocked writes, flags-only writes, ALU updates and an attempt to write a privileged mode back, together with the ignored-write pulse and its one-cycle width.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int NUM_FIELDS = 4;
    localparam int FLD_CTRL   = 0;
    localparam int FLD_EXT    = 1;
    localparam int FLD_STAT   = 2;
    localparam int FLD_FLAG   = 3;

    typedef enum logic {
        LVL_PRIV = 1'b0,
        LVL_USER = 1'b1
    } priv_lvl_t;
endpackage

// File: rtl/psr_field_gate.sv
module psr_field_gate
    import psr_pkg::*;
#(
    parameter int                 MODE_W    = 5,
    parameter logic [MODE_W-1:0]  USER_MODE = 5'b10000
) (
    input  logic                  wr_en,
    input  logic [NUM_FIELDS-1:0] wr_mask,
    input  logic [MODE_W-1:0]     cur_mode,
    output logic [NUM_FIELDS-1:0] byte_en,
    output logic                  blocked
);
    localparam logic [NUM_FIELDS-1:0] USER_OK = NUM_FIELDS'(1) << FLD_FLAG;

    priv_lvl_t lvl;

    always_comb begin
        lvl = (cur_mode == USER_MODE) ? LVL_USER : LVL_PRIV;
    end

    always_comb begin
        byte_en = '0;
        blocked = 1'b0;
        if (wr_en) begin
            unique case (lvl)
                LVL_PRIV: begin
                    byte_en = wr_mask;
                end
                LVL_USER: begin
                    byte_en = wr_mask & USER_OK;
                    blocked = |(wr_mask & ~USER_OK);
                end
            endcase
        end
    end
endmodule

// File: rtl/psr_byte_merge.sv
module psr_byte_merge
    import psr_pkg::*;
#(
    parameter int FIELD_W = 8,
    parameter int NFLAG   = 4,
    localparam int DATA_W = NUM_FIELDS * FIELD_W
) (
    input  logic [DATA_W-1:0]     cur,
    input  logic [DATA_W-1:0]     src,
    input  logic [NUM_FIELDS-1:0] byte_en,
    input  logic                  alu_we,
    input  logic [NFLAG-1:0]      alu_flags,
    output logic [DATA_W-1:0]     nxt
);
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_lane
        logic [FIELD_W-1:0] cur_b;
        logic [FIELD_W-1:0] src_b;
        assign cur_b = cur[g*FIELD_W +: FIELD_W];
        assign src_b = src[g*FIELD_W +: FIELD_W];
        if (g == FLD_FLAG) begin : g_flag
            always_comb begin
                if (byte_en[g])
                    nxt[g*FIELD_W +: FIELD_W] = src_b;
                else if (alu_we)
                    nxt[g*FIELD_W +: FIELD_W] = {alu_flags, cur_b[FIELD_W-NFLAG-1:0]};
                else
                    nxt[g*FIELD_W +: FIELD_W] = cur_b;
            end
        end else begin : g_plain
            assign nxt[g*FIELD_W +: FIELD_W] = byte_en[g] ? src_b : cur_b;
        end
    end
endmodule

// File: rtl/psr_reg.sv
module psr_reg
    import psr_pkg::*;
#(
    parameter int                FIELD_W    = 8,
    parameter int                NFLAG      = 4,
    parameter int                MODE_W     = 5,
    parameter logic [MODE_W-1:0] USER_MODE  = 5'b10000,
    parameter logic [MODE_W-1:0] RESET_MODE = 5'b10011,
    parameter int                IRQ_BIT    = 7,
    parameter int                FIQ_BIT    = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [3:0]                     wr_mask,
    input  logic                           wr_src_imm,
    input  logic [4*FIELD_W-1:0]           wr_reg_data,
    input  logic [4*FIELD_W-1:0]           wr_imm_data,
    input  logic                           alu_flag_we,
    input  logic [NFLAG-1:0]               alu_flags,
    output logic [4*FIELD_W-1:0]           rd_data,
    output logic                           irq_off,
    output logic [MODE_W-1:0]              mode,
    output logic                           wr_ignored
);
    localparam int DATA_W = NUM_FIELDS * FIELD_W;
    localparam logic [DATA_W-1:0] RESET_VAL = (DATA_W'(1) << IRQ_BIT)
                                            | (DATA_W'(1) << FIQ_BIT)
                                            | DATA_W'(RESET_MODE);

    logic [DATA_W-1:0]     psr_q;
    logic [DATA_W-1:0]     psr_d;
    logic [DATA_W-1:0]     src_data;
    logic [NUM_FIELDS-1:0] byte_en;
    logic                  blocked;
    logic                  ign_q;

    assign src_data = wr_src_imm ? wr_imm_data : wr_reg_data;

    psr_field_gate #(
        .MODE_W    (MODE_W),
        .USER_MODE (USER_MODE)
    ) u_gate (
        .wr_en    (wr_en),
        .wr_mask  (wr_mask),
        .cur_mode (psr_q[MODE_W-1:0]),
        .byte_en  (byte_en),
        .blocked  (blocked)
    );

    psr_byte_merge #(
        .FIELD_W (FIELD_W),
        .NFLAG   (NFLAG)
    ) u_merge (
        .cur       (psr_q),
        .src       (src_data),
        .byte_en   (byte_en),
        .alu_we    (alu_flag_we),
        .alu_flags (alu_flags),
        .nxt       (psr_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psr_q <= RESET_VAL;
            ign_q <= 1'b0;
        end else begin
            psr_q <= psr_d;
            ign_q <= blocked;
        end
    end

    always_comb begin
        rd_data    = psr_q;
        irq_off    = psr_q[IRQ_BIT];
        mode       = psr_q[MODE_W-1:0];
        wr_ignored = ign_q;
    end
endmodule

// File: rtl/psr_reg_chk.sv
module psr_reg_chk #(
    parameter int                FIELD_W   = 8,
    parameter int                NFLAG     = 4,
    parameter int                MODE_W    = 5,
    parameter logic [MODE_W-1:0] USER_MODE = 5'b10000
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [3:0]           wr_mask,
    input logic                 wr_src_imm,
    input logic [4*FIELD_W-1:0] wr_reg_data,
    input logic [4*FIELD_W-1:0] wr_imm_data,
    input logic                 alu_flag_we,
    input logic [NFLAG-1:0]     alu_flags,
    input logic [4*FIELD_W-1:0] rd_data,
    input logic [MODE_W-1:0]    mode,
    input logic                 wr_ignored
);
    localparam int DW = 4 * FIELD_W;

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !alu_flag_we) |=> $stable(rd_data)); // R2

    AST_USER_LOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode == USER_MODE) |=> rd_data[DW-FIELD_W-1:0] == $past(rd_data[DW-FIELD_W-1:0])); // R5

    AST_ALU_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_flag_we && !(wr_en && wr_mask[3])) |=> rd_data[DW-1 -: NFLAG] == $past(alu_flags)); // R6

    AST_SW_FLAGS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mask[3]) |=> rd_data[DW-1 -: FIELD_W] == $past(wr_src_imm ? wr_imm_data[DW-1 -: FIELD_W] : wr_reg_data[DW-1 -: FIELD_W])); // R7

    AST_IGN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ignored |-> $past(wr_en && mode == USER_MODE && (|wr_mask[2:0]))); // R8

    AST_IGN_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode == USER_MODE && (|wr_mask[2:0])) |=> wr_ignored); // R8
endmodule

bind psr_reg psr_reg_chk #(
    .FIELD_W   (FIELD_W),
    .NFLAG     (NFLAG),
    .MODE_W    (MODE_W),
    .USER_MODE (USER_MODE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_mask     (wr_mask),
    .wr_src_imm  (wr_src_imm),
    .wr_reg_data (wr_reg_data),
    .wr_imm_data (wr_imm_data),
    .alu_flag_we (alu_flag_we),
    .alu_flags   (alu_flags),
    .rd_data     (rd_data),
    .mode        (mode),
    .wr_ignored  (wr_ignored)
);

// File: tb/psr_reg_test.sv
module psr_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_mask = '0;
    logic        wr_src_imm = 1'b0;
    logic [31:0] wr_reg_data = '0;
    logic [31:0] wr_imm_data = '0;
    logic        alu_flag_we = 1'b0;
    logic [3:0]  alu_flags = '0;
    logic [31:0] rd_data;
    logic        irq_off;
    logic [4:0]  mode;
    logic        wr_ignored;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    psr_reg uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask),
        .wr_src_imm(wr_src_imm), .wr_reg_data(wr_reg_data), .wr_imm_data(wr_imm_data),
        .alu_flag_we(alu_flag_we), .alu_flags(alu_flags), .rd_data(rd_data),
        .irq_off(irq_off), .mode(mode), .wr_ignored(wr_ignored)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // drive one cycle of stimulus at a falling edge, release at the next
    task automatic cycle(input logic we, input logic [3:0] m, input logic imm,
                         input logic [31:0] rdat, input logic [31:0] idat,
                         input logic awe, input logic [3:0] af);
        @(negedge clk);
        wr_en = we; wr_mask = m; wr_src_imm = imm;
        wr_reg_data = rdat; wr_imm_data = idat;
        alu_flag_we = awe; alu_flags = af;
        @(negedge clk);
        wr_en = 1'b0; wr_mask = '0; wr_src_imm = 1'b0;
        wr_reg_data = '0; wr_imm_data = '0; alu_flag_we = 1'b0; alu_flags = '0;
    endtask

    task automatic t_reset();
        check("R1 rd_data", rd_data, 32'h000000D3);
        check("R1 irq_off", 32'(irq_off), 32'd1);
        check("R1 mode", 32'(mode), 32'h13);
        check("R1 wr_ignored", 32'(wr_ignored), 32'd0);
    endtask

    task automatic t_masked();
        cycle(1'b1, 4'b0110, 1'b0, 32'hAABBCC93, 32'hFFFFFFFF, 1'b0, 4'h0);
        check("R2 ext+status lanes", rd_data, 32'h00BBCCD3);
        check("R8 no pulse when privileged", 32'(wr_ignored), 32'd0);
        cycle(1'b0, 4'b1111, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 4'h0);
        check("R2 mask without enable", rd_data, 32'h00BBCCD3);
    endtask

    task automatic t_source_and_irq();
        cycle(1'b1, 4'b0001, 1'b1, 32'hEEEEEEEE, 32'h11223353, 1'b0, 4'h0);
        check("R3 immediate source", rd_data, 32'h00BBCC53);
        check("R4 irq_off cleared", 32'(irq_off), 32'd0);
        check("R4 mode out", 32'(mode), 32'h13);
    endtask

    task automatic t_alu();
        cycle(1'b1, 4'b1000, 1'b0, 32'h0F000000, 32'h0, 1'b0, 4'h0);
        check("R2 flags lane", rd_data, 32'h0FBBCC53);
        cycle(1'b0, 4'b0000, 1'b0, 32'h0, 32'h0, 1'b1, 4'b1010);
        check("R6 alu nibble only", rd_data, 32'hAFBBCC53);
    endtask

    task automatic t_conflict();
        cycle(1'b1, 4'b1000, 1'b0, 32'h35000000, 32'h0, 1'b1, 4'b1111);
        check("R7 software wins flags", rd_data, 32'h35BBCC53);
        cycle(1'b1, 4'b0100, 1'b0, 32'h00440000, 32'h0, 1'b1, 4'b0110);
        check("R7 both apply on disjoint bytes", rd_data, 32'h6544CC53);
    endtask

    task automatic t_enter_user();
        cycle(1'b1, 4'b0001, 1'b0, 32'h00000090, 32'h0, 1'b0, 4'h0);
        check("R9 privileged write enters user", rd_data, 32'h6544CC90);
        check("R9 mode user", 32'(mode), 32'h10);
        check("R4 irq_off set", 32'(irq_off), 32'd1);
        check("R8 no pulse on entry", 32'(wr_ignored), 32'd0);
    endtask

    task automatic t_user_block();
        cycle(1'b1, 4'b1111, 1'b0, 32'h12345678, 32'h0, 1'b0, 4'h0);
        check("R5 only flags written", rd_data, 32'h1244CC90);
        check("R8 pulse raised", 32'(wr_ignored), 32'd1);
        @(negedge clk);
        check("R8 pulse one cycle", 32'(wr_ignored), 32'd0);
        check("R9 still user", 32'(mode), 32'h10);
    endtask

    task automatic t_user_flags();
        cycle(1'b1, 4'b1000, 1'b1, 32'hFFFFFFFF, 32'h77000000, 1'b0, 4'h0);
        check("R5 user flags write", rd_data, 32'h7744CC90);
        check("R8 flags-only no pulse", 32'(wr_ignored), 32'd0);
        cycle(1'b0, 4'b0000, 1'b0, 32'h0, 32'h0, 1'b1, 4'b0001);
        check("R6 alu in user mode", rd_data, 32'h1744CC90);
    endtask

    task automatic t_user_escape();
        cycle(1'b1, 4'b0001, 1'b0, 32'h00000013, 32'h0, 1'b0, 4'h0);
        check("R9 cannot leave user", rd_data, 32'h1744CC90);
        check("R8 pulse on control attempt", 32'(wr_ignored), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked();
        t_source_and_irq();
        t_alu();
        t_conflict();
        t_enter_user();
        t_user_block();
        t_user_flags();
        t_user_escape();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule